// File: doc/BRIEF.md
# Serial EEPROM Streaming Reader

This block is a bus master for a two-wire serial EEPROM at a fixed 7-bit device address (default 1010000b). One command gives a 16-bit start location and a count of two-byte reads. The first transfer is addressed. The master sends a write-mode header and the two location bytes, then a repeated START and a read-mode header. It then reads two bytes. Each later transfer is a plain read: START, read-mode header and two bytes. The EEPROM's own address counter supplies the contiguous data.

The master drives the clock line directly. It pulls the data line low through an output enable, so an external pull-up makes it open drain. The clock low time and high time come from two programmable divider values. Received bytes leave on a byte bus with a one-clock valid strobe. A missing acknowledge on any header or location byte raises a sticky error flag. The block then sends STOP and ends the command.

Top module: `eepromStreamReader`

## Requirements
- R1: After reset, `sclOut` is 1, `sdaOe` is 0, and `busy`, `byteValid` and `nackErr` are 0. The divider values hold their parameter defaults.
- R2: When idle, the block accepts `cmdValid` with a nonzero `cmdPairs`, and `busy` is 1 on the next clock. A command with `cmdPairs` = 0 is ignored. `cmdValid` is also ignored while `busy` is 1.
- R3: The first transfer of a command is START, byte A0h (device address, then R/W = 0 for write), `cmdPtr[15:8]`, `cmdPtr[7:0]`, repeated START, then byte A1h (R/W = 1 for read).
- R4: Every transfer reads exactly two bytes. The master acknowledges the first byte (data low in the ninth clock) and not the second (data released). It then sends STOP.
- R5: A command makes exactly `cmdPairs` transfers. Each transfer after the first is START, A1h and two bytes. `busy` stays 1 from acceptance until the last STOP has completed.
- R6: All bytes are shifted most significant bit first. The output stream is the EEPROM contents from `cmdPtr` upward, in order.
- R7: `byteValid` is a one-clock pulse for each received byte, `2*cmdPairs` pulses per command, with the byte on `byteData`.
- R8: If the slave does not acknowledge A0h, a location byte or A1h, the block sets `nackErr`, sends STOP and returns to idle without delivering more bytes. `nackErr` clears when the next command is accepted.
- R9: Each clock-low phase lasts exactly tLow clocks. Each data-bit high phase lasts exactly tHigh clocks. A `cfgWe` while idle loads tHigh from `cfgHigh` with a minimum of 1, and tLow from `cfgLow` with a minimum of 2. A `cfgWe` while `busy` is ignored.
- R10: The data line only changes while the clock line is low, except for the START, repeated START and STOP conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Divider write strobe |
| cfgHigh | input | 16 | Clock high time in clocks |
| cfgLow | input | 16 | Clock low time in clocks |
| cmdValid | input | 1 | Command strobe |
| cmdPtr | input | 16 | EEPROM start location |
| cmdPairs | input | 8 | Number of two-byte reads |
| sdaIn | input | 1 | Sampled data line |
| sclOut | output | 1 | Clock line |
| sdaOe | output | 1 | 1 pulls the data line low |
| byteData | output | 8 | Received byte |
| byteValid | output | 1 | One-clock strobe for `byteData` |
| nackErr | output | 1 | Sticky missing-acknowledge flag |
| busy | output | 1 | Command in progress |

## Verification
`busy` is due on the first clock after an accepted command. The bench drives the command on a falling edge and samples `busy` on the next falling edge. Line timing is measured in clocks: every clock-low run must equal tLow exactly, and no high run may be shorter than tHigh. The bench measures runs on falling edges, where each register change is already settled.

Byte strobes follow the ninth clock of each byte by a clock. The bench therefore gathers them on every falling edge. It compares them with the bench's memory model, and with the headers, acknowledges and STOPs its slave model decoded, only once `busy` has fallen.

// File: rtl/eeprd_pkg.sv
package eeprd_pkg;
  typedef enum logic [2:0] {
    OP_START, OP_RESTART, OP_STOP, OP_TX, OP_RX
  } busOp_e;

  typedef struct packed {
    logic   go;
    busOp_e op;
    logic [7:0] txByte;
    logic   rxNack;
    logic   cfgLock;
  } ctlStrobe_t;

  typedef struct packed {
    logic   done;
    logic   slaveAck;
    logic [7:0] rxByte;
  } dpStatus_t;
endpackage

// File: rtl/eeprdBitEngine.sv
module eeprdBitEngine
  import eeprd_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DEF_HIGH = 300,
  parameter int DEF_LOW  = 300
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic             cfgWe,
  input  logic [DIV_W-1:0] cfgHigh,
  input  logic [DIV_W-1:0] cfgLow,
  input  logic             sdaIn,
  output dpStatus_t        stat,
  output logic             sclOut,
  output logic             sdaOe
);
  localparam int ACK_SLOT = 8;
  localparam logic [DIV_W-1:0] MIN_HIGH = DIV_W'(1);
  localparam logic [DIV_W-1:0] MIN_LOW  = DIV_W'(2);

  logic [DIV_W-1:0] tHigh, tLow, cnt;
  logic             active, sclReg, sdaLowReg, ackReg, doneReg, nackReg;
  busOp_e           opReg;
  logic [1:0]       seg;
  logic [3:0]       bitNo;
  logic [7:0]       shiftReg;

  function automatic logic [DIV_W-1:0] segLen(busOp_e op, logic [1:0] s,
                                               logic [DIV_W-1:0] hi, logic [DIV_W-1:0] lo);
    if (op == OP_START) return hi;
    case (s)
      2'd0:    return lo >> 1;
      2'd1:    return lo - (lo >> 1);
      default: return hi;
    endcase
  endfunction

  // returns {scl, sdaLow}
  function automatic logic [1:0] segDrive(busOp_e op, logic [1:0] s,
                                          logic dataLow, logic prevLow);
    case (op)
      OP_START: return 2'b11;
      OP_RESTART:
        case (s)
          2'd0: return {1'b0, prevLow};
          2'd1: return 2'b00;
          2'd2: return 2'b10;
          default: return 2'b11;
        endcase
      OP_STOP:
        case (s)
          2'd0: return {1'b0, prevLow};
          2'd1: return 2'b01;
          2'd2: return 2'b11;
          default: return 2'b10;
        endcase
      default:
        if (s == 2'd0) return {1'b0, prevLow};
        else return {s == 2'd2, dataLow};
    endcase
  endfunction

  logic       isByte, segEnd, lastSeg, slotsDone, finish, sampleNow, dataLowN;
  logic [1:0] nSeg;
  logic [3:0] nBit;
  logic [7:0] shiftNext;

  always_comb begin
    isByte    = (opReg == OP_TX) || (opReg == OP_RX);
    segEnd    = active && (cnt == '0);
    lastSeg   = (opReg == OP_START) ? 1'b1 : (isByte ? (seg == 2'd2) : (seg == 2'd3));
    slotsDone = isByte ? (bitNo == 4'(ACK_SLOT)) : 1'b1;
    finish    = segEnd && lastSeg && slotsDone;
    nSeg      = lastSeg ? 2'd0 : seg + 2'd1;
    nBit      = lastSeg ? bitNo + 4'd1 : bitNo;
    sampleNow = segEnd && isByte && (seg == 2'd2);
    shiftNext = (sampleNow && bitNo < 4'(ACK_SLOT)) ? {shiftReg[6:0], sdaIn} : shiftReg;
    if (opReg == OP_TX) dataLowN = (nBit < 4'(ACK_SLOT)) ? ~shiftNext[7] : 1'b0;
    else                dataLowN = (nBit < 4'(ACK_SLOT)) ? 1'b0 : ~nackReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tHigh     <= DIV_W'(DEF_HIGH);
      tLow      <= DIV_W'(DEF_LOW);
      active    <= 1'b0;
      opReg     <= OP_STOP;
      seg       <= 2'd0;
      bitNo     <= 4'd0;
      cnt       <= '0;
      shiftReg  <= 8'd0;
      nackReg   <= 1'b0;
      sclReg    <= 1'b1;
      sdaLowReg <= 1'b0;
      ackReg    <= 1'b0;
      doneReg   <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (cfgWe && !ctl.cfgLock && !active) begin
        tHigh <= (cfgHigh < MIN_HIGH) ? MIN_HIGH : cfgHigh;
        tLow  <= (cfgLow  < MIN_LOW)  ? MIN_LOW  : cfgLow;
      end
      if (!active) begin
        if (ctl.go) begin
          active   <= 1'b1;
          opReg    <= ctl.op;
          shiftReg <= ctl.txByte;
          nackReg  <= ctl.rxNack;
          seg      <= 2'd0;
          bitNo    <= 4'd0;
          cnt      <= segLen(ctl.op, 2'd0, tHigh, tLow) - DIV_W'(1);
          {sclReg, sdaLowReg} <= segDrive(ctl.op, 2'd0, 1'b0, sdaLowReg);
        end
      end else if (cnt != '0) begin
        cnt <= cnt - DIV_W'(1);
      end else begin
        shiftReg <= shiftNext;
        if (sampleNow && bitNo == 4'(ACK_SLOT)) ackReg <= ~sdaIn;
        if (finish) begin
          active  <= 1'b0;
          doneReg <= 1'b1;
        end else begin
          seg   <= nSeg;
          bitNo <= nBit;
          cnt   <= segLen(opReg, nSeg, tHigh, tLow) - DIV_W'(1);
          {sclReg, sdaLowReg} <= segDrive(opReg, nSeg, dataLowN, sdaLowReg);
        end
      end
    end
  end

  assign sclOut        = sclReg;
  assign sdaOe         = sdaLowReg;
  assign stat.done     = doneReg;
  assign stat.slaveAck = ackReg;
  assign stat.rxByte   = shiftReg;

  // R10: data line moves under a high clock only for bus conditions
  a_r10_sda_quiet_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclReg && $past(sclReg) && (sdaLowReg != $past(sdaLowReg)))
      |-> (opReg inside {OP_START, OP_RESTART, OP_STOP}));

  // R9: a clock-low phase never lasts a single clock
  a_r9_low_min: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclReg) |=> !sclReg);

  // R9: programmed divider values respect their minimums
  a_r9_div_floor: assert property (@(posedge clk) disable iff (!rstN)
    (tLow >= MIN_LOW) && (tHigh >= MIN_HIGH));
endmodule

// File: rtl/eeprdSequencer.sv
module eeprdSequencer
  import eeprd_pkg::*;
#(
  parameter int         CNT_W    = 8,
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [15:0]      cmdPtr,
  input  logic [CNT_W-1:0] cmdPairs,
  input  dpStatus_t        stat,
  output ctlStrobe_t       ctl,
  output logic [7:0]       byteData,
  output logic             byteValid,
  output logic             nackErr,
  output logic             busy
);
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDRW, S_PTRHI, S_PTRLO,
    S_RESTART, S_ADDRR, S_RDHI, S_RDLO, S_STOP
  } seqState_e;

  seqState_e        state;
  logic             issue, firstXfer, errReg, validReg;
  logic [15:0]      ptrReg;
  logic [CNT_W-1:0] pairsLeft;
  logic [7:0]       byteReg;

  always_comb begin
    ctl.go      = issue && (state != S_IDLE);
    ctl.rxNack  = (state == S_RDLO);
    ctl.cfgLock = (state != S_IDLE);
    ctl.txByte  = 8'd0;
    case (state)
      S_START:   ctl.op = OP_START;
      S_RESTART: ctl.op = OP_RESTART;
      S_RDHI, S_RDLO: ctl.op = OP_RX;
      S_ADDRW, S_PTRHI, S_PTRLO, S_ADDRR: ctl.op = OP_TX;
      default:   ctl.op = OP_STOP;
    endcase
    case (state)
      S_ADDRW: ctl.txByte = {DEV_ADDR, 1'b0};
      S_PTRHI: ctl.txByte = ptrReg[15:8];
      S_PTRLO: ctl.txByte = ptrReg[7:0];
      S_ADDRR: ctl.txByte = {DEV_ADDR, 1'b1};
      default: ctl.txByte = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      issue     <= 1'b0;
      firstXfer <= 1'b0;
      errReg    <= 1'b0;
      validReg  <= 1'b0;
      ptrReg    <= 16'd0;
      pairsLeft <= '0;
      byteReg   <= 8'd0;
    end else begin
      validReg <= 1'b0;
      if (ctl.go) issue <= 1'b0;
      if (state == S_IDLE) begin
        if (cmdValid && cmdPairs != '0) begin
          ptrReg    <= cmdPtr;
          pairsLeft <= cmdPairs;
          firstXfer <= 1'b1;
          errReg    <= 1'b0;
          state     <= S_START;
          issue     <= 1'b1;
        end
      end else if (stat.done) begin
        issue <= 1'b1;
        case (state)
          S_START: state <= firstXfer ? S_ADDRW : S_ADDRR;
          S_ADDRW, S_PTRHI, S_PTRLO, S_ADDRR:
            if (!stat.slaveAck) begin
              errReg <= 1'b1;
              state  <= S_STOP;
            end else begin
              case (state)
                S_ADDRW: state <= S_PTRHI;
                S_PTRHI: state <= S_PTRLO;
                S_PTRLO: state <= S_RESTART;
                default: state <= S_RDHI;
              endcase
            end
          S_RESTART: state <= S_ADDRR;
          S_RDHI: begin
            byteReg  <= stat.rxByte;
            validReg <= 1'b1;
            state    <= S_RDLO;
          end
          S_RDLO: begin
            byteReg   <= stat.rxByte;
            validReg  <= 1'b1;
            pairsLeft <= pairsLeft - CNT_W'(1);
            firstXfer <= 1'b0;
            state     <= S_STOP;
          end
          default:
            if (!errReg && pairsLeft != '0) state <= S_START;
            else begin
              state <= S_IDLE;
              issue <= 1'b0;
            end
        endcase
      end
    end
  end

  assign byteData  = byteReg;
  assign byteValid = validReg;
  assign nackErr   = errReg;
  assign busy      = (state != S_IDLE);

  // R7: the byte strobe is a single-clock pulse
  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R8: no byte is delivered once the error flag is up
  a_r8_no_data_on_err: assert property (@(posedge clk) disable iff (!rstN)
    nackErr |-> !byteValid);

  // R5: busy only drops when the bit engine has just finished a bus operation
  a_r5_busy_end_on_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(stat.done));

  // R2: an accepted command makes the block busy on the next clock
  a_r2_accept: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdPairs != '0) |=> busy);
endmodule

// File: rtl/eepromStreamReader.sv
module eepromStreamReader
  import eeprd_pkg::*;
#(
  parameter int         DIV_W    = 16,
  parameter int         CNT_W    = 8,
  parameter int         DEF_HIGH = 300,
  parameter int         DEF_LOW  = 300,
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [DIV_W-1:0] cfgHigh,
  input  logic [DIV_W-1:0] cfgLow,
  input  logic             cmdValid,
  input  logic [15:0]      cmdPtr,
  input  logic [CNT_W-1:0] cmdPairs,
  input  logic             sdaIn,
  output logic             sclOut,
  output logic             sdaOe,
  output logic [7:0]       byteData,
  output logic             byteValid,
  output logic             nackErr,
  output logic             busy
);
  ctlStrobe_t ctl;
  dpStatus_t  stat;

  eeprdSequencer #(.CNT_W(CNT_W), .DEV_ADDR(DEV_ADDR)) i_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdPtr(cmdPtr),
    .cmdPairs(cmdPairs), .stat(stat), .ctl(ctl), .byteData(byteData),
    .byteValid(byteValid), .nackErr(nackErr), .busy(busy)
  );

  eeprdBitEngine #(.DIV_W(DIV_W), .DEF_HIGH(DEF_HIGH), .DEF_LOW(DEF_LOW)) i_eng (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgWe(cfgWe), .cfgHigh(cfgHigh),
    .cfgLow(cfgLow), .sdaIn(sdaIn), .stat(stat), .sclOut(sclOut), .sdaOe(sdaOe)
  );
endmodule

// File: tb/test_eepromStreamReader.sv
module test_eepromStreamReader;
  localparam int DH = 5;
  localparam int DL = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [15:0] cfgHigh = 16'd0, cfgLow = 16'd0;
  logic cmdValid = 1'b0;
  logic [15:0] cmdPtr = 16'd0;
  logic [7:0] cmdPairs = 8'd0;
  logic slaveLow = 1'b0;
  logic sdaIn, sclOut, sdaOe, byteValid, nackErr, busy;
  logic [7:0] byteData;

  always #4 clk = ~clk;
  assign sdaIn = !(sdaOe || slaveLow);

  eepromStreamReader #(.DEF_HIGH(DH), .DEF_LOW(DL)) i_eepromStreamReader (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgHigh(cfgHigh), .cfgLow(cfgLow),
    .cmdValid(cmdValid), .cmdPtr(cmdPtr), .cmdPairs(cmdPairs), .sdaIn(sdaIn),
    .sclOut(sclOut), .sdaOe(sdaOe), .byteData(byteData), .byteValid(byteValid),
    .nackErr(nackErr), .busy(busy)
  );

  int checks = 0, failures = 0;
  int curHi = DH, curLo = DL;

  function automatic logic [7:0] memf(logic [15:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hC3;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave model and monitors
  logic prevScl = 1'b1, prevSda = 1'b1, prevValid = 1'b0;
  int sMode = 0, sBit = 0, recvCount = 0, nackAt = 0;
  bit ackRise = 0, sAcked = 0, mAck = 0;
  logic [7:0] sSh = 0, sTx = 0, pHi = 0, wAddr = 0;
  logic [15:0] sPtr = 0, ptrSeen = 0;
  int startCnt = 0, stopCnt = 0, mAckCnt = 0, mNackCnt = 0, ptrLoads = 0;
  int gotN = 0, dblValid = 0, runLen = 0, lowBad = 0, highShort = 0, highExact = 0;
  logic [7:0] got [0:15];
  int cycles = 0;

  always @(negedge clk) begin
    cycles++;
    if (byteValid) begin
      if (gotN < 16) got[gotN] = byteData;
      gotN++;
      if (prevValid) dblValid++;
    end
    prevValid = byteValid;
    if (sclOut != prevScl) begin
      if (busy && !prevScl && runLen != curLo) lowBad++;
      if (busy && prevScl) begin
        if (runLen < curHi) highShort++;
        if (runLen == curHi) highExact++;
      end
      runLen = 1;
    end else runLen++;
    if (prevScl && sclOut && prevSda && !sdaIn) begin
      sMode = 1; sBit = 0; ackRise = 0; startCnt++; slaveLow = 0;
    end else if (prevScl && sclOut && !prevSda && sdaIn) begin
      sMode = 0; stopCnt++; slaveLow = 0;
    end else if (!prevScl && sclOut && sMode != 0) begin
      if (sBit < 8) begin
        if (sMode != 4) sSh = {sSh[6:0], sdaIn};
        sBit++;
      end else begin
        if (sMode == 4) mAck = !sdaIn;
        ackRise = 1;
      end
    end else if (prevScl && !sclOut && sMode != 0) begin
      if (ackRise) begin
        ackRise = 0; sBit = 0; slaveLow = 0;
        case (sMode)
          1: if (!sAcked) sMode = 0;
             else if (sSh[0]) begin sMode = 4; sTx = memf(sPtr); slaveLow = !sTx[7]; end
             else begin sMode = 2; wAddr = sSh; end
          2: if (sAcked) begin pHi = sSh; sMode = 3; end else sMode = 0;
          3: begin
               if (sAcked) begin sPtr = {pHi, sSh}; ptrSeen = sPtr; ptrLoads++; end
               sMode = 0;
             end
          default:
            if (mAck) begin
              mAckCnt++; sPtr = sPtr + 16'd1; sTx = memf(sPtr); slaveLow = !sTx[7];
            end else begin
              mNackCnt++; sPtr = sPtr + 16'd1; sMode = 0;
            end
        endcase
      end else if (sBit == 8) begin
        if (sMode == 4) slaveLow = 0;
        else begin
          recvCount++;
          sAcked = (recvCount != nackAt) && (sMode != 1 || sSh[7:1] == 7'b1010000);
          slaveLow = sAcked;
        end
      end else if (sMode == 4) slaveLow = !sTx[7 - sBit];
    end
    prevScl = sclOut;
    prevSda = sdaIn;
  end

  task automatic runCmd(input logic [15:0] ptr, input int pairs, input int nk, input bit disturb);
    int wait_n;
    int mism;
    startCnt = 0; stopCnt = 0; mAckCnt = 0; mNackCnt = 0; ptrLoads = 0; ptrSeen = 16'hDEAD;
    gotN = 0; dblValid = 0; lowBad = 0; highShort = 0; highExact = 0;
    recvCount = 0; nackAt = nk; wAddr = 0;
    @(negedge clk);
    cmdValid = 1; cmdPtr = ptr; cmdPairs = 8'(pairs);
    @(negedge clk);
    cmdValid = 0;
    check(busy == 1'b1, "R2", busy, 1);
    wait_n = 0;
    while (busy && wait_n < 60000) begin
      @(negedge clk);
      wait_n++;
      if (disturb && wait_n == 40) begin
        cmdValid = 1; cmdPtr = ptr ^ 16'h00F0; cmdPairs = 8'd5;
        cfgWe = 1; cfgHigh = 16'd9; cfgLow = 16'd9;
      end
      if (disturb && wait_n == 41) begin cmdValid = 0; cfgWe = 0; end
    end
    check(!busy, "R5 command finished", busy, 0);
    check(dblValid == 0, "R7 single pulse", dblValid, 0);
    check(lowBad == 0 && highShort == 0 && highExact > 0, "R9 clock timing",
          lowBad + highShort, 0);
    if (nk == 0) begin
      check(nackErr == 1'b0, "R8 flag clear", nackErr, 0);
      check(gotN == 2 * pairs, "R7 byte count", gotN, 2 * pairs);
      mism = 0;
      for (int k = 0; k < 2 * pairs && k < 16; k++)
        if (got[k] !== memf(ptr + 16'(k))) mism++;
      check(mism == 0, "R6 data order", mism, 0);
      check(wAddr == 8'hA0 && ptrLoads == 1 && ptrSeen == ptr, "R3 pointer set",
            int'(ptrSeen), int'(ptr));
      check(startCnt == pairs + 1, "R5 transfers", startCnt, pairs + 1);
      check(mAckCnt == pairs && mNackCnt == pairs, "R4 ack pattern",
            mAckCnt * 100 + mNackCnt, pairs * 101);
      check(stopCnt == pairs, "R4 stops", stopCnt, pairs);
    end else begin
      check(nackErr == 1'b1, "R8 flag set", nackErr, 1);
      check(gotN == (nk == 5 ? 2 : 0), "R8 bytes", gotN, nk == 5 ? 2 : 0);
      check(stopCnt == (nk == 5 ? 2 : 1), "R8 stop sent", stopCnt, nk == 5 ? 2 : 1);
    end
    check(sclOut && !sdaOe, "R1 bus idle", {sclOut, sdaOe}, 2);
  endtask

  task automatic setCfg(input int hi, input int lo, input int expHi, input int expLo);
    @(negedge clk);
    cfgWe = 1; cfgHigh = 16'(hi); cfgLow = 16'(lo);
    @(negedge clk);
    cfgWe = 0;
    curHi = expHi; curLo = expLo;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(sclOut == 1'b1 && sdaOe == 1'b0, "R1 lines", {sclOut, sdaOe}, 2);
    check(!busy && !byteValid && !nackErr, "R1 flags", {busy, byteValid, nackErr}, 0);
    // R1 / R9: defaults in force
    runCmd(16'h0000, 1, 0, 0);
    // R2: zero count ignored
    @(negedge clk);
    cmdValid = 1; cmdPairs = 8'd0; cmdPtr = 16'h0100;
    @(negedge clk);
    cmdValid = 0;
    check(!busy, "R2 zero count", busy, 0);
    repeat (20) @(negedge clk);
    check(startCnt == 1 + 1 && sclOut, "R2 no bus activity", startCnt, 2);
    // R2 / R9: command and divider write during busy ignored
    runCmd(16'h2040, 2, 0, 1);
    // R9 sweep over divider settings, including clamped minimums
    for (int c = 0; c < 3; c++) begin
      if (c == 0) setCfg(3, 5, 3, 5);
      else if (c == 1) setCfg(0, 0, 1, 2);
      else setCfg(2, 4, 2, 4);
      for (int p = 0; p < 4; p++)
        for (int n = 1; n <= 3; n++)
          runCmd(p == 0 ? 16'h0000 : p == 1 ? 16'h01FE : p == 2 ? 16'hFFFF : 16'h1234,
                 n, 0, 0);
    end
    // R8: missing acknowledge at each addressed byte
    for (int k = 1; k <= 5; k++) runCmd(16'h0777, 2, k, 0);
    runCmd(16'h0033, 1, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule